// File: doc/BRIEF.md
# Calendar Time Counter With Update Inhibit

This block keeps wall-clock time from seconds up to the century. A fast timebase strobe feeds a sub-second divider; once per divided second the block advances seconds, minutes, hours, day of week, day of month, month, year and century in a single clock cycle. The carry logic follows real month lengths and adds 29 February in every year divisible by four.

A host reaches the block through a small indexed register port. Each write places one byte at an index. Reads are combinational from a separate read index. Two control bits choose how time values cross the port: binary or BCD, and 12-hour or 24-hour hours. Internally the time is always held in binary 24-hour form, so changing either format bit never alters the stored time.

A freeze bit stops the divider and the once-per-second advance, so the host can load a consistent time. When the bit is cleared, counting restarts from the written values and a full second passes before the first advance. A status flag goes high a fixed number of timebase cycles before each advance. This warns the host that the registers are about to change.

Top module: `cal_time_counter`

## Requirements
- R1: After reset the time reads 00:00:00, day of week 1, date 1, month 1, year 0 and century 20 (read as 0x20), the control index reads 0x02, and the status index reads 0x00.
- R2: With freeze clear, one advance happens every DIV_COUNT cycles in which tick_en is high. Seconds step from 59 to 0 and carry into minutes, minutes carry into hours at 59, and hours wrap from 23 to 0.
- R3: The day of month wraps to 1 after day 30 in months 4, 6, 9 and 11, and after day 31 in the other months except February. Each wrap advances the month, and month 12 wraps to 1.
- R4: February ends after day 29 when the binary year is divisible by 4, and after day 28 otherwise.
- R5: The year wraps from 99 to 0 and carries one into the century, which itself wraps from 99 to 0.
- R6: The day of week advances with every day change and wraps from 7 to 1.
- R7: Control bit 2 selects the port encoding, 1 for binary and 0 for packed BCD. It applies to both reads and writes of all time fields, and changing it leaves the stored time unchanged.
- R8: Control bit 1 selects the hour format, 1 for 24-hour and 0 for 12-hour. In 12-hour form the hours read and write as 12, 1 to 11, with bit 7 set for PM. So midnight reads 0x12 and 13:00 reads 0x81 in BCD.
- R9: Control bit 7 is the freeze bit. While it is set, no advance happens, and host writes still land. After it clears, the first advance comes exactly DIV_COUNT enabled cycles after the clearing write.
- R10: Status index bit 7 is high during the last UIP_LEAD enabled cycles of each second, that is, from divider count DIV_COUNT-UIP_LEAD up to the advance. It is low in the cycle after an advance and whenever freeze is set.
- R11: The index map is: seconds 0x0, minutes 0x2, hours 0x4, day of week 0x6, date 0x7, month 0x8, year 0x9, status 0xA, control 0xB, century 0xE. Indices 0x1, 0x3 and 0x5 are reserved slots: they read 0, and writes to them change nothing.
- R12: Cycles with tick_en low do not advance the divider, so the time holds until the strobe returns.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_en | input | 1 | Timebase strobe enabling one divider count |
| wr_en | input | 1 | Host write strobe |
| wr_idx | input | 4 | Host write index |
| wr_data | input | 8 | Host write byte in the selected encoding |
| rd_idx | input | 4 | Host read index |
| rd_data | output | 8 | Byte at rd_idx in the selected encoding |

## Verification
The assertions assume that the host writes only in-range calendar values in the encoding currently selected, with the day of week kept within 1 to 7. The day and weekday pairing check holds only for such values. They also assume UIP_LEAD is smaller than DIV_COUNT, so an advance always falls inside the warning window and the window closes right after it. The stimulus loads every time value under freeze, or as a single in-range hour write, and always uses the encoding that is active at that moment. It keeps the divider short (40 counts, 8-count window), so every rollover is reached by presetting a value one second before the boundary.

// File: rtl/cal_pkg.sv
`timescale 1ns/1ps
package cal_pkg;

  localparam int IDX_W  = 4;
  localparam int DATA_W = 8;
  localparam int NF     = 8;

  localparam logic [IDX_W-1:0] IX_SEC  = 4'h0;
  localparam logic [IDX_W-1:0] IX_MIN  = 4'h2;
  localparam logic [IDX_W-1:0] IX_HR   = 4'h4;
  localparam logic [IDX_W-1:0] IX_DOW  = 4'h6;
  localparam logic [IDX_W-1:0] IX_DOM  = 4'h7;
  localparam logic [IDX_W-1:0] IX_MON  = 4'h8;
  localparam logic [IDX_W-1:0] IX_YR   = 4'h9;
  localparam logic [IDX_W-1:0] IX_STAT = 4'hA;
  localparam logic [IDX_W-1:0] IX_CTRL = 4'hB;
  localparam logic [IDX_W-1:0] IX_CEN  = 4'hE;

  // field slots used for the write strobes
  localparam int F_SEC = 0;
  localparam int F_MIN = 1;
  localparam int F_HR  = 2;
  localparam int F_DOW = 3;
  localparam int F_DOM = 4;
  localparam int F_MON = 5;
  localparam int F_YR  = 6;
  localparam int F_CEN = 7;

  localparam logic [IDX_W-1:0] FIELD_IX [NF] =
    '{IX_SEC, IX_MIN, IX_HR, IX_DOW, IX_DOM, IX_MON, IX_YR, IX_CEN};

  // time held in binary, 24-hour form
  typedef struct packed {
    logic [6:0] cen;
    logic [6:0] yr;
    logic [3:0] mon;
    logic [4:0] dom;
    logic [2:0] dow;
    logic [4:0] hr;
    logic [5:0] mn;
    logic [5:0] sec;
  } cal_time_t;

  typedef struct packed {
    logic freeze;
    logic bin_mode;
    logic h24;
  } cal_ctrl_t;

  // binary value to port byte
  function automatic logic [7:0] fmt_out(input logic [6:0] v, input logic bin);
    logic [3:0] tens;
    logic [3:0] ones;
    tens = 4'(v / 7'd10);
    ones = 4'(v % 7'd10);
    return bin ? {1'b0, v} : {tens, ones};
  endfunction

  // port byte to binary value
  function automatic logic [6:0] fmt_in(input logic [7:0] d, input logic bin);
    logic [6:0] r;
    r = 7'({3'd0, d[7:4]} * 7'd10) + {3'd0, d[3:0]};
    return bin ? d[6:0] : r;
  endfunction

  function automatic logic [4:0] month_days(input logic [3:0] mon, input logic [6:0] yr);
    case (mon)
      4'd2:                   month_days = (yr[1:0] == 2'b00) ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11: month_days = 5'd30;
      default:                month_days = 5'd31;
    endcase
  endfunction

endpackage

// File: rtl/cal_divider.sv
`timescale 1ns/1ps
module cal_divider #(
  parameter int DIV_COUNT = 32768,
  parameter int UIP_LEAD  = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en,
  input  logic freeze,
  output logic upd,
  output logic uip
);
  localparam int DW = (DIV_COUNT > 2) ? $clog2(DIV_COUNT) : 1;
  localparam logic [DW-1:0] LAST = DW'(DIV_COUNT - 1);
  localparam logic [DW-1:0] WIN  = DW'(DIV_COUNT - UIP_LEAD);

  logic [DW-1:0] div_q;
  logic [DW-1:0] div_d;
  logic          div_en;

  assign div_en = freeze | tick_en;

  always_comb begin
    div_d = div_q;
    upd   = 1'b0;
    if (freeze) begin
      div_d = '0;
    end else if (tick_en) begin
      if (div_q == LAST) begin
        div_d = '0;
        upd   = 1'b1;
      end else begin
        div_d = div_q + 1'b1;
      end
    end
  end

  assign uip = !freeze && (div_q >= WIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
    end else if (div_en) begin
      div_q <= div_d;
    end
  end
endmodule

// File: rtl/cal_rollover.sv
`timescale 1ns/1ps
module cal_rollover
  import cal_pkg::*;
(
  input  cal_time_t cur,
  output cal_time_t nxt
);
  logic       c_min, c_hr, c_day, c_mon, c_yr, c_cen;
  logic [4:0] mlen;

  always_comb begin
    nxt  = cur;
    mlen = month_days(cur.mon, cur.yr);

    c_min   = (cur.sec >= 6'd59);
    nxt.sec = c_min ? 6'd0 : cur.sec + 6'd1;

    c_hr = c_min && (cur.mn >= 6'd59);
    if (c_min) nxt.mn = (cur.mn >= 6'd59) ? 6'd0 : cur.mn + 6'd1;

    c_day = c_hr && (cur.hr >= 5'd23);
    if (c_hr) nxt.hr = (cur.hr >= 5'd23) ? 5'd0 : cur.hr + 5'd1;

    c_mon = c_day && (cur.dom >= mlen);
    if (c_day) begin
      nxt.dom = (cur.dom >= mlen) ? 5'd1 : cur.dom + 5'd1;
      nxt.dow = (cur.dow >= 3'd7) ? 3'd1 : cur.dow + 3'd1;
    end

    c_yr = c_mon && (cur.mon >= 4'd12);
    if (c_mon) nxt.mon = (cur.mon >= 4'd12) ? 4'd1 : cur.mon + 4'd1;

    c_cen = c_yr && (cur.yr >= 7'd99);
    if (c_yr) nxt.yr = (cur.yr >= 7'd99) ? 7'd0 : cur.yr + 7'd1;

    if (c_cen) nxt.cen = (cur.cen >= 7'd99) ? 7'd0 : cur.cen + 7'd1;
  end
endmodule

// File: rtl/cal_port_codec.sv
`timescale 1ns/1ps
module cal_port_codec
  import cal_pkg::*;
(
  input  cal_time_t           now,
  input  cal_ctrl_t           ctrl,
  input  logic                uip,
  input  logic [IDX_W-1:0]    rd_idx,
  input  logic                wr_en,
  input  logic [IDX_W-1:0]    wr_idx,
  input  logic [DATA_W-1:0]   wr_data,
  output logic [DATA_W-1:0]   rd_data,
  output cal_time_t           wr_val,
  output logic [NF-1:0]       we_fld,
  output logic                ctrl_we,
  output cal_ctrl_t           ctrl_wv
);
  logic       bin;
  logic [4:0] h12_in, hr_base, hr12_dec;
  logic [4:0] h12_out;
  logic [7:0] hr_rd;

  assign bin = ctrl.bin_mode;

  for (genvar g = 0; g < NF; g++) begin : g_we
    assign we_fld[g] = wr_en && (wr_idx == FIELD_IX[g]);
  end

  assign ctrl_we        = wr_en && (wr_idx == IX_CTRL);
  assign ctrl_wv.freeze = wr_data[7];
  assign ctrl_wv.bin_mode = wr_data[2];
  assign ctrl_wv.h24    = wr_data[1];

  // write-side decode
  always_comb begin
    h12_in   = 5'(fmt_in({1'b0, wr_data[6:0]}, bin));
    hr_base  = (h12_in == 5'd12) ? 5'd0 : h12_in;
    hr12_dec = wr_data[7] ? hr_base + 5'd12 : hr_base;

    wr_val.sec = 6'(fmt_in(wr_data, bin));
    wr_val.mn  = 6'(fmt_in(wr_data, bin));
    wr_val.hr  = ctrl.h24 ? 5'(fmt_in(wr_data, bin)) : hr12_dec;
    wr_val.dow = 3'(fmt_in(wr_data, bin));
    wr_val.dom = 5'(fmt_in(wr_data, bin));
    wr_val.mon = 4'(fmt_in(wr_data, bin));
    wr_val.yr  = fmt_in(wr_data, bin);
    wr_val.cen = fmt_in(wr_data, bin);
  end

  // read-side encode
  always_comb begin
    if (now.hr == 5'd0)       h12_out = 5'd12;
    else if (now.hr > 5'd12)  h12_out = now.hr - 5'd12;
    else                      h12_out = now.hr;

    if (ctrl.h24) hr_rd = fmt_out({2'd0, now.hr}, bin);
    else          hr_rd = {now.hr >= 5'd12, 7'(fmt_out({2'd0, h12_out}, bin))};

    case (rd_idx)
      IX_SEC:  rd_data = fmt_out({1'b0, now.sec}, bin);
      IX_MIN:  rd_data = fmt_out({1'b0, now.mn}, bin);
      IX_HR:   rd_data = hr_rd;
      IX_DOW:  rd_data = fmt_out({4'd0, now.dow}, bin);
      IX_DOM:  rd_data = fmt_out({2'd0, now.dom}, bin);
      IX_MON:  rd_data = fmt_out({3'd0, now.mon}, bin);
      IX_YR:   rd_data = fmt_out(now.yr, bin);
      IX_CEN:  rd_data = fmt_out(now.cen, bin);
      IX_STAT: rd_data = {uip, 7'd0};
      IX_CTRL: rd_data = {ctrl.freeze, 4'd0, ctrl.bin_mode, ctrl.h24, 1'b0};
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/cal_time_counter.sv
`timescale 1ns/1ps
module cal_time_counter
  import cal_pkg::*;
#(
  parameter int DIV_COUNT = 32768,
  parameter int UIP_LEAD  = 8,
  parameter int CEN_RESET = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);
  logic [1:0] rs_q;
  logic       rst_int_n;

  cal_time_t  now_q, now_d, nxt_time, wr_val;
  cal_ctrl_t  ctrl_q, ctrl_d, ctrl_wv;
  logic [NF-1:0] we_fld;
  logic       ctrl_we, now_en;
  logic       upd, uip;

  // reset: asserted at once, released after two clocks
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  cal_divider #(.DIV_COUNT(DIV_COUNT), .UIP_LEAD(UIP_LEAD)) u_div (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .tick_en (tick_en),
    .freeze  (ctrl_q.freeze),
    .upd     (upd),
    .uip     (uip)
  );

  cal_rollover u_roll (
    .cur (now_q),
    .nxt (nxt_time)
  );

  cal_port_codec u_codec (
    .now     (now_q),
    .ctrl    (ctrl_q),
    .uip     (uip),
    .rd_idx  (rd_idx),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .wr_val  (wr_val),
    .we_fld  (we_fld),
    .ctrl_we (ctrl_we),
    .ctrl_wv (ctrl_wv)
  );

  // next state: advance, then per-field host overrides
  always_comb begin
    now_d = upd ? nxt_time : now_q;
    if (we_fld[F_SEC]) now_d.sec = wr_val.sec;
    if (we_fld[F_MIN]) now_d.mn  = wr_val.mn;
    if (we_fld[F_HR])  now_d.hr  = wr_val.hr;
    if (we_fld[F_DOW]) now_d.dow = wr_val.dow;
    if (we_fld[F_DOM]) now_d.dom = wr_val.dom;
    if (we_fld[F_MON]) now_d.mon = wr_val.mon;
    if (we_fld[F_YR])  now_d.yr  = wr_val.yr;
    if (we_fld[F_CEN]) now_d.cen = wr_val.cen;
  end

  assign now_en = upd | (|we_fld);
  assign ctrl_d = ctrl_wv;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      now_q <= '{cen: 7'(CEN_RESET), yr: 7'd0, mon: 4'd1, dom: 5'd1,
                 dow: 3'd1, hr: 5'd0, mn: 6'd0, sec: 6'd0};
    end else if (now_en) begin
      now_q <= now_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      ctrl_q <= '{freeze: 1'b0, bin_mode: 1'b0, h24: 1'b1};
    end else if (ctrl_we) begin
      ctrl_q <= ctrl_d;
    end
  end
endmodule

// File: rtl/cal_time_counter_chk.sv
`timescale 1ns/1ps
module cal_time_counter_chk
  import cal_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input logic      wr_en,
  input logic      upd,
  input logic      uip,
  input logic      freeze,
  input cal_time_t now
);
  AST_UPDATE_INSIDE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    upd |-> uip); // R10

  AST_WINDOW_CLOSES_AFTER_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> !uip); // R10

  AST_HOLD_WHILE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze && !wr_en) |=> $stable(now)); // R9

  AST_NO_CHANGE_WITHOUT_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd && !wr_en) |=> $stable(now)); // R12

  AST_SECOND_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !wr_en && now.sec < 6'd59) |=> now.sec == 6'($past(now.sec) + 6'd1)); // R2

  AST_SECOND_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !wr_en && now.sec == 6'd59) |=> now.sec == 6'd0); // R2

  AST_WEEKDAY_FOLLOWS_DATE: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !wr_en) |=> ((now.dom != $past(now.dom)) == (now.dow != $past(now.dow)))); // R6
endmodule

bind cal_time_counter cal_time_counter_chk i_chk (
  .clk    (clk),
  .rst_n  (rst_int_n),
  .wr_en  (wr_en),
  .upd    (upd),
  .uip    (uip),
  .freeze (ctrl_q.freeze),
  .now    (now_q)
);

// File: tb/test_cal_time_counter.sv
`timescale 1ns/1ps
module test_cal_time_counter;
  localparam int DIV  = 40;
  localparam int LEAD = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b1;
  logic       wr_en = 1'b0;
  logic [3:0] wr_idx = '0;
  logic [7:0] wr_data = '0;
  logic [3:0] rd_idx = '0;
  logic [7:0] rd_data;

  typedef struct {
    logic [3:0] idx;
    logic [7:0] exp;
    string      tag;
  } item_t;

  item_t sb_q[$];
  int    pend = 0;
  int    n_chk = 0;
  int    n_err = 0;
  bit    done = 1'b0;

  always #2.5 clk = ~clk;

  cal_time_counter #(.DIV_COUNT(DIV), .UIP_LEAD(LEAD), .CEN_RESET(20)) i_cal_time_counter (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_en (tick_en),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .rd_idx  (rd_idx),
    .rd_data (rd_data)
  );

  // monitor: one scoreboard item per cycle, sampled mid-low phase
  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      if (sb_q.size() != 0) begin
        it = sb_q.pop_front();
        rd_idx = it.idx;
        #0.5;
        n_chk++;
        if (rd_data !== it.exp) begin
          n_err++;
          $display("FAIL %s idx=%h actual=%h expected=%h", it.tag, it.idx, rd_data, it.exp);
        end
        pend--;
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic host_wr(input logic [3:0] idx, input logic [7:0] d);
    wr_en = 1'b1; wr_idx = idx; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic expect_rd(input logic [3:0] idx, input logic [7:0] v, input string tag);
    item_t it;
    it.idx = idx; it.exp = v; it.tag = tag;
    sb_q.push_back(it);
    pend++;
    wait (pend == 0);
  endtask

  task automatic load_time(input logic [7:0] ctrl, input logic [7:0] s, input logic [7:0] m,
                           input logic [7:0] h, input logic [7:0] dw, input logic [7:0] dm,
                           input logic [7:0] mo, input logic [7:0] y, input logic [7:0] c);
    host_wr(4'hB, ctrl | 8'h80);
    host_wr(4'h0, s);  host_wr(4'h2, m);  host_wr(4'h4, h);
    host_wr(4'h6, dw); host_wr(4'h7, dm); host_wr(4'h8, mo);
    host_wr(4'h9, y);  host_wr(4'hE, c);
    host_wr(4'hB, ctrl);
  endtask

  // one second before midnight, then check the date after one advance
  task automatic day_case(input logic [7:0] dm, input logic [7:0] mo, input logic [7:0] y,
                          input logic [7:0] dw, input logic [7:0] e_dm, input logic [7:0] e_mo,
                          input logic [7:0] e_dw, input string tag);
    load_time(8'h02, 8'h59, 8'h59, 8'h23, dw, dm, mo, y, 8'h20);
    step(DIV + DIV / 2);
    expect_rd(4'h7, e_dm, tag);
    expect_rd(4'h8, e_mo, tag);
    expect_rd(4'h6, e_dw, tag);
  endtask

  initial begin
    #100000;
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    step(3);

    // R1 reset state
    expect_rd(4'h0, 8'h00, "R1 sec");
    expect_rd(4'h2, 8'h00, "R1 min");
    expect_rd(4'h4, 8'h00, "R1 hour");
    expect_rd(4'h6, 8'h01, "R1 dow");
    expect_rd(4'h7, 8'h01, "R1 date");
    expect_rd(4'h8, 8'h01, "R1 month");
    expect_rd(4'h9, 8'h00, "R1 year");
    expect_rd(4'hE, 8'h20, "R1 century");
    expect_rd(4'hB, 8'h02, "R1 control");
    expect_rd(4'hA, 8'h00, "R1 status");

    // R9 freeze holds, R10 flag low while frozen
    host_wr(4'hB, 8'h82);
    host_wr(4'h0, 8'h58); host_wr(4'h2, 8'h59); host_wr(4'h4, 8'h23);
    host_wr(4'h6, 8'h07); host_wr(4'h7, 8'h31); host_wr(4'h8, 8'h12);
    host_wr(4'h9, 8'h99); host_wr(4'hE, 8'h19);
    step(2 * DIV);
    expect_rd(4'h0, 8'h58, "R9 frozen sec");
    expect_rd(4'hA, 8'h00, "R10 low while frozen");

    // release: first advance exactly DIV cycles later, flag window LEAD long
    host_wr(4'hB, 8'h02);
    step(DIV - LEAD - 1);
    expect_rd(4'hA, 8'h00, "R10 before window");
    step(1);
    expect_rd(4'hA, 8'h80, "R10 window open");
    step(LEAD - 1);
    expect_rd(4'h0, 8'h58, "R9 no advance before DIV");
    step(1);
    expect_rd(4'h0, 8'h59, "R9 advance at DIV");
    step(1);
    expect_rd(4'hA, 8'h00, "R10 window closed");

    // second advance: full rollover to new century
    step(DIV + DIV / 2 - 1);
    expect_rd(4'h0, 8'h00, "R2 sec wrap");
    expect_rd(4'h2, 8'h00, "R2 min wrap");
    expect_rd(4'h4, 8'h00, "R2 hour wrap");
    expect_rd(4'h6, 8'h01, "R6 dow 7 to 1");
    expect_rd(4'h7, 8'h01, "R3 date wrap dec");
    expect_rd(4'h8, 8'h01, "R3 month wrap");
    expect_rd(4'h9, 8'h00, "R5 year wrap");
    expect_rd(4'hE, 8'h20, "R5 century carry");

    // month lengths and leap years
    day_case(8'h28, 8'h02, 8'h03, 8'h03, 8'h01, 8'h03, 8'h04, "R4 feb plain year");
    day_case(8'h28, 8'h02, 8'h04, 8'h02, 8'h29, 8'h02, 8'h03, "R4 feb leap year");
    day_case(8'h29, 8'h02, 8'h04, 8'h05, 8'h01, 8'h03, 8'h06, "R4 leap day end");
    day_case(8'h30, 8'h04, 8'h10, 8'h01, 8'h01, 8'h05, 8'h02, "R3 april end");
    day_case(8'h30, 8'h01, 8'h10, 8'h06, 8'h31, 8'h01, 8'h07, "R3 january day 31");

    // minute and hour carry without day change
    load_time(8'h02, 8'h59, 8'h59, 8'h10, 8'h05, 8'h15, 8'h06, 8'h21, 8'h20);
    step(DIV + DIV / 2);
    expect_rd(4'h4, 8'h11, "R2 hour carry");
    expect_rd(4'h2, 8'h00, "R2 minute carry");
    expect_rd(4'h7, 8'h15, "R2 date unchanged");

    // binary encoding, then switch to BCD
    load_time(8'h06, 8'h14, 8'h2D, 8'h0D, 8'h03, 8'h0A, 8'h03, 8'h18, 8'h14);
    step(DIV + DIV / 2);
    expect_rd(4'h0, 8'h15, "R7 binary sec");
    expect_rd(4'h4, 8'h0D, "R7 binary hour");
    expect_rd(4'h7, 8'h0A, "R7 binary date");
    host_wr(4'hB, 8'h02);
    expect_rd(4'h4, 8'h13, "R7 bcd hour after switch");
    expect_rd(4'h2, 8'h45, "R7 bcd min after switch");
    expect_rd(4'hE, 8'h20, "R7 bcd century");

    // 12-hour presentation and PM flag
    host_wr(4'hB, 8'h00);
    expect_rd(4'h4, 8'h81, "R8 1 pm");
    host_wr(4'h4, 8'h92);
    expect_rd(4'h4, 8'h92, "R8 noon readback");
    host_wr(4'hB, 8'h02);
    expect_rd(4'h4, 8'h12, "R8 noon in 24h");
    host_wr(4'hB, 8'h00);
    host_wr(4'h4, 8'h12);
    host_wr(4'hB, 8'h02);
    expect_rd(4'h4, 8'h00, "R8 midnight in 24h");

    // 12-hour rollover 11 pm to 12 am
    load_time(8'h00, 8'h59, 8'h59, 8'h91, 8'h02, 8'h10, 8'h05, 8'h20, 8'h20);
    step(DIV + DIV / 2);
    expect_rd(4'h4, 8'h12, "R8 12 am");
    expect_rd(4'h7, 8'h11, "R8 date after 11 pm");
    expect_rd(4'h6, 8'h03, "R6 dow step");
    host_wr(4'hB, 8'h02);
    expect_rd(4'h4, 8'h00, "R8 hour 0 in 24h");

    // reserved slots
    host_wr(4'hB, 8'h82);
    host_wr(4'h0, 8'h10);
    host_wr(4'h1, 8'h33); host_wr(4'h3, 8'h44); host_wr(4'h5, 8'h55);
    expect_rd(4'h1, 8'h00, "R11 slot 1");
    expect_rd(4'h3, 8'h00, "R11 slot 3");
    expect_rd(4'h5, 8'h00, "R11 slot 5");
    expect_rd(4'h0, 8'h10, "R11 sec untouched");
    expect_rd(4'h2, 8'h00, "R11 min untouched");
    expect_rd(4'h4, 8'h00, "R11 hour untouched");

    // strobe gating
    tick_en = 1'b0;
    host_wr(4'hB, 8'h02);
    step(3 * DIV);
    expect_rd(4'h0, 8'h10, "R12 held without strobe");
    expect_rd(4'hA, 8'h00, "R12 divider idle");
    tick_en = 1'b1;
    step(DIV - 1);
    expect_rd(4'h0, 8'h10, "R12 not yet advanced");
    step(1);
    expect_rd(4'h0, 8'h11, "R12 advance after strobe resumes");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule